// File: doc/BRIEF.md
# Direct torque control switching selector with minimum dwell

This block chooses the three inverter leg commands of a direct torque control drive. Each sample it takes the estimated torque, the estimated flux magnitude and the two orthogonal flux components, all computed elsewhere. It runs a two-level hysteresis comparator on torque and another on flux. It places the flux vector in one of six 60° sectors and looks up a voltage vector from the sector and the two comparator states.

The looked-up vector is not applied directly. Each leg has its own dwell counter. A leg that differs from its applied state may switch only when its counter has run out. A refused change is not stored: the table is evaluated again at the next sample and the leg switches at the first sample where a change is both requested and permitted. The minimum dwell is a runtime input counted in samples. For a 2 µs sample and a 30 µs minimum switching time it is set to 15.

Top module: `dtc_switch_gate`

## Requirements
- R1: While reset is low, and after it is released until the first sample, `legs` is 000.
- R2: At a sample, the torque raise state is set when `torque_est < torque_ref - torque_band`, cleared when `torque_est > torque_ref + torque_band`, and kept otherwise, so both band edges are inclusive.
- R3: At a sample, the flux raise state is set when `flux_mag < flux_ref - flux_band`, cleared when `flux_mag > flux_ref + flux_band`, and kept otherwise.
- R4: The sector s (0..5) is the flux angle atan2(`flux_q`, `flux_d`) taken in [0°, 360°) and divided by 60°, rounded down. The zero vector falls in sector 0. The test for the 60° lines compares q² with 3·d² exactly.
- R5: Vectors are numbered V1..V6 as (a,b,c) = 100, 110, 010, 011, 001, 101, with a on `legs[2]` and c on `legs[0]`. Let k = s+1, with vector numbers taken modulo 6. The requested vector is V(k+1) for torque raise with flux raise, V(k+2) for torque raise with flux lower, and V(k-1) for torque lower with flux raise. For torque lower with flux lower it is 000 when k is odd and 111 when k is even.
- R6: `legs` changes only in the clock cycle after a cycle in which `sample_strobe` is high.
- R7: A leg whose requested value differs from its applied value, and whose dwell has run out, takes the requested value on that sample. With `hold_samples` of 0 or 1 every requested change is applied.
- R8: After a leg switches at sample n with `hold_samples` = H at that sample, the leg cannot switch again before sample n+H. A later change of `hold_samples` does not shorten or extend a dwell already running.
- R9: A change refused during the dwell is re-evaluated at every later sample. It is applied at the first sample where the dwell has ended and the table still requests it.
- R10: Each leg has its own dwell. A leg in dwell does not prevent the other legs from switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_strobe | input | 1 | One-cycle pulse that marks a control sample |
| torque_ref | input | W | Torque reference, signed |
| torque_est | input | W | Estimated torque, signed |
| torque_band | input | W | Torque hysteresis half-width, non-negative |
| flux_ref | input | W | Flux magnitude reference, signed |
| flux_mag | input | W | Estimated flux magnitude, signed |
| flux_band | input | W | Flux hysteresis half-width, non-negative |
| flux_d | input | W | Direct flux component, signed |
| flux_q | input | W | Quadrature flux component, signed |
| hold_samples | input | HW | Minimum dwell per leg, in samples |
| legs | output | 3 | Applied leg commands a, b, c (bit 2 to bit 0) |

## Verification
The hardest case to reach is a refused change on one leg that must be replayed later while the other two legs switch freely. This needs a long dwell, several legs in dwell with different end points, and table requests that keep changing in the meantime. The stimulus sets a dwell of 15 and steps the flux angle through the sectors at every sample. This staggers the three legs' dwell windows. It also changes the dwell value while windows are open, to show that a running window keeps the value it started with. A reference model in the bench computes the sector with floating-point atan2, which is independent of the exact integer test in the design.

// File: rtl/dtc_switch_gate.sv
module dtc_switch_gate #(
  parameter int W  = 16,
  parameter int HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_strobe,
  input  logic signed [W-1:0]  torque_ref,
  input  logic signed [W-1:0]  torque_est,
  input  logic signed [W-1:0]  torque_band,
  input  logic signed [W-1:0]  flux_ref,
  input  logic signed [W-1:0]  flux_mag,
  input  logic signed [W-1:0]  flux_band,
  input  logic signed [W-1:0]  flux_d,
  input  logic signed [W-1:0]  flux_q,
  input  logic [HW-1:0]        hold_samples,
  output logic [2:0]           legs
);
  localparam int PW = 2*W + 2;

  logic tq_q, fx_q, tq_n, fx_n;
  logic signed [W:0] t_e, t_lo, t_hi, f_e, f_lo, f_hi;

  assign t_e  = $signed({torque_est[W-1], torque_est});
  assign t_lo = $signed({torque_ref[W-1], torque_ref}) - $signed({torque_band[W-1], torque_band});
  assign t_hi = $signed({torque_ref[W-1], torque_ref}) + $signed({torque_band[W-1], torque_band});
  assign f_e  = $signed({flux_mag[W-1], flux_mag});
  assign f_lo = $signed({flux_ref[W-1], flux_ref}) - $signed({flux_band[W-1], flux_band});
  assign f_hi = $signed({flux_ref[W-1], flux_ref}) + $signed({flux_band[W-1], flux_band});

  assign tq_n = (t_e < t_lo) ? 1'b1 : (t_e > t_hi) ? 1'b0 : tq_q;
  assign fx_n = (f_e < f_lo) ? 1'b1 : (f_e > f_hi) ? 1'b0 : fx_q;

  logic [W-1:0]  ad, aq;
  logic [PW-1:0] q2, d3;
  logic          steep, upper;
  logic [2:0]    sector;

  assign ad    = flux_d[W-1] ? W'(-flux_d) : W'(flux_d);
  assign aq    = flux_q[W-1] ? W'(-flux_q) : W'(flux_q);
  assign q2    = PW'(aq) * PW'(aq);
  assign d3    = PW'(ad) * PW'(ad) * PW'(3);
  assign steep = q2 > d3;
  assign upper = !flux_q[W-1] && !((flux_q == '0) && flux_d[W-1]);

  always_comb begin
    if (upper) sector = steep ? 3'd1 : (flux_d[W-1] ? 3'd2 : 3'd0);
    else       sector = steep ? 3'd4 : (flux_d[W-1] ? 3'd3 : 3'd5);
  end

  function automatic logic [2:0] vec_at(input logic [2:0] s, input logic [2:0] step);
    logic [3:0] j;
    j = {1'b0, s} + {1'b0, step};
    if (j >= 4'd6) j = j - 4'd6;
    case (j[2:0])
      3'd0:    vec_at = 3'b100;
      3'd1:    vec_at = 3'b110;
      3'd2:    vec_at = 3'b010;
      3'd3:    vec_at = 3'b011;
      3'd4:    vec_at = 3'b001;
      default: vec_at = 3'b101;
    endcase
  endfunction

  logic [2:0] want;
  always_comb begin
    case ({tq_n, fx_n})
      2'b11:   want = vec_at(sector, 3'd1);
      2'b10:   want = vec_at(sector, 3'd2);
      2'b01:   want = vec_at(sector, 3'd5);
      default: want = sector[0] ? 3'b111 : 3'b000;
    endcase
  end

  logic [HW-1:0] reload;
  logic [HW-1:0] cnt [3];

  assign reload = (hold_samples == '0) ? '0 : hold_samples - HW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq_q <= 1'b0;
      fx_q <= 1'b0;
      legs <= 3'b000;
      for (int i = 0; i < 3; i++) cnt[i] <= '0;
    end else if (sample_strobe) begin
      tq_q <= tq_n;
      fx_q <= fx_n;
      for (int i = 0; i < 3; i++) begin
        if (want[i] != legs[i] && cnt[i] == '0) begin
          legs[i] <= want[i];
          cnt[i]  <= reload;
        end else if (cnt[i] != '0) begin
          cnt[i] <= cnt[i] - HW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dtc_switch_gate_chk.sv
module dtc_switch_gate_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_strobe,
  input logic [HW-1:0] hold_samples,
  input logic [2:0]    legs
);
  logic [2:0]    last;
  logic [HW-1:0] hold_d;
  logic [HW:0]   since [3];
  logic [HW-1:0] lh [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last   <= 3'b000;
      hold_d <= '0;
      for (int i = 0; i < 3; i++) begin
        since[i] <= '1;
        lh[i]    <= '0;
      end
    end else begin
      last   <= legs;
      hold_d <= hold_samples;
      for (int i = 0; i < 3; i++) begin
        if (legs[i] != last[i]) begin
          since[i] <= sample_strobe ? (HW+1)'(1) : '0;
          lh[i]    <= hold_d;
        end else if (sample_strobe && since[i] != '1) begin
          since[i] <= since[i] + (HW+1)'(1);
        end
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> legs == 3'b000);

  p_known_r1: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(legs));

  p_only_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(legs));

  for (genvar g = 0; g < 3; g++) begin : g_leg
    p_dwell_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (legs[g] != last[g]) |-> (since[g] >= {1'b0, lh[g]}));
  end
endmodule

bind dtc_switch_gate dtc_switch_gate_chk #(.HW(HW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .sample_strobe(sample_strobe),
  .hold_samples(hold_samples),
  .legs(legs)
);

// File: tb/test_dtc_switch_gate.sv
module test_dtc_switch_gate;
  localparam int W  = 16;
  localparam int HW = 8;
  localparam int TU = 900,  TD = 1100, TH = 1000;
  localparam int FU = 700,  FD = 900,  FH = 800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic sample_strobe = 1'b0;
  logic signed [W-1:0] torque_ref = 16'sd1000, torque_est = '0, torque_band = 16'sd50;
  logic signed [W-1:0] flux_ref = 16'sd800, flux_mag = '0, flux_band = 16'sd20;
  logic signed [W-1:0] flux_d = '0, flux_q = '0;
  logic [HW-1:0] hold_samples = '0;
  logic [2:0] legs;

  dtc_switch_gate #(.W(W), .HW(HW)) i_dtc_switch_gate (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
    .torque_ref(torque_ref), .torque_est(torque_est), .torque_band(torque_band),
    .flux_ref(flux_ref), .flux_mag(flux_mag), .flux_band(flux_band),
    .flux_d(flux_d), .flux_q(flux_q), .hold_samples(hold_samples), .legs(legs)
  );

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t q_exp[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int m_tq = 0, m_fx = 0, n_s = 0;
  logic [2:0] m_leg = 3'b000;
  int m_last[3] = '{-1000, -1000, -1000};
  int m_hold[3] = '{0, 0, 0};

  int cd[6] = '{866, 0, -866, -866, 0, 866};
  int cq[6] = '{500, 1000, 500, -500, -1000, -500};

  function automatic logic [2:0] vnum(input int n);
    int j;
    j = ((n - 1) % 6 + 6) % 6;
    case (j)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  task automatic check_now(input logic [2:0] exp, input string tag);
    checks++;
    if (legs !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, legs, exp);
    end
  endtask

  task automatic sample(input int te, input int fm, input int fd, input int fq, input string tag);
    real ang;
    int sec, k;
    logic [2:0] want;
    item_t it;
    @(negedge clk);
    torque_est = W'(te); flux_mag = W'(fm); flux_d = W'(fd); flux_q = W'(fq);
    sample_strobe = 1'b1;
    if (te < 1000 - 50) m_tq = 1; else if (te > 1000 + 50) m_tq = 0;
    if (fm < 800 - 20) m_fx = 1; else if (fm > 800 + 20) m_fx = 0;
    ang = $atan2(real'(fq), real'(fd)) * 180.0 / 3.14159265358979;
    if (ang < 0.0) ang = ang + 360.0;
    sec = int'($floor(ang / 60.0));
    if (sec > 5) sec = 5;
    k = sec + 1;
    if (m_tq == 1 && m_fx == 1)      want = vnum(k + 1);
    else if (m_tq == 1)              want = vnum(k + 2);
    else if (m_fx == 1)              want = vnum(k - 1);
    else                             want = (k % 2 == 1) ? 3'b000 : 3'b111;
    for (int i = 0; i < 3; i++) begin
      if (want[i] != m_leg[i] && (n_s - m_last[i]) >= m_hold[i]) begin
        m_leg[i]  = want[i];
        m_last[i] = n_s;
        m_hold[i] = int'(hold_samples);
      end
    end
    n_s++;
    it.exp = m_leg;
    it.tag = tag;
    q_exp.push_back(it);
    @(negedge clk);
    sample_strobe = 1'b0;
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (sample_strobe === 1'b1) begin
        @(negedge clk);
        checks++;
        if (q_exp.size() == 0) begin
          fails++;
          $display("FAIL R6 scoreboard: actual=%b expected=no result", legs);
        end else begin
          it = q_exp.pop_front();
          if (legs !== it.exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", it.tag, legs, it.exp);
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check_now(3'b000, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_now(3'b000, "R1 after release");

    hold_samples = 8'd0;
    for (int s = 0; s < 6; s++) sample(TU, FU, cd[s], cq[s], "R4 R5 R7 raise/raise");
    for (int s = 0; s < 6; s++) sample(TD, FU, cd[s], cq[s], "R5 torque lower");
    for (int s = 0; s < 6; s++) sample(TU, FD, cd[s], cq[s], "R5 flux lower");
    for (int s = 0; s < 6; s++) sample(TD, FD, cd[s], cq[s], "R5 zero vector");

    sample(TU, FU, 866, 500, "R2 set raise");
    sample(TH, FU, 866, 500, "R2 inside band keeps raise");
    sample(1050, FU, 866, 500, "R2 upper edge keeps raise");
    sample(TD, FU, 866, 500, "R2 clear raise");
    sample(950, FU, 866, 500, "R2 lower edge keeps lower");
    sample(TU, FU, 866, 500, "R2 raise again");

    sample(TU, FD, 866, 500, "R3 flux lower");
    sample(TU, FH, 866, 500, "R3 inside band keeps lower");
    sample(TU, 780, 866, 500, "R3 lower edge keeps lower");
    sample(TU, FU, 866, 500, "R3 flux raise");
    sample(TU, 820, 866, 500, "R3 upper edge keeps raise");

    sample(TU, FU, 1000, 0, "R4 positive d axis");
    sample(TU, FU, 500, 866, "R4 just below 60");
    sample(TU, FU, 500, 867, "R4 just above 60");
    sample(TU, FU, -1000, 0, "R4 negative d axis");
    sample(TU, FU, 0, -1000, "R4 negative q axis");
    sample(TU, FU, 0, 1000, "R4 positive q axis");
    sample(TU, FU, 0, 0, "R4 zero flux");

    @(negedge clk);
    held = legs;
    torque_est = 16'sd1500; flux_d = -16'sd700; flux_q = -16'sd300;
    repeat (5) @(negedge clk);
    check_now(held, "R6 no strobe no change");

    hold_samples = 8'd15;
    for (int j = 0; j < 40; j++) sample(TU, FU, cd[j % 6], cq[j % 6], "R8 R9 R10 dwell 15");
    for (int j = 0; j < 20; j++) sample((j % 3 == 0) ? TD : TU, FU, cd[0], cq[0], "R9 deferred retry");

    hold_samples = 8'd3;
    for (int j = 0; j < 4; j++) sample(TU, FU, cd[j % 6], cq[j % 6], "R8 dwell 3");
    hold_samples = 8'd0;
    for (int j = 0; j < 8; j++) sample(TU, FU, cd[(j + 2) % 6], cq[(j + 2) % 6], "R8 running dwell kept");

    hold_samples = 8'd1;
    for (int j = 0; j < 12; j++) sample(TU, (j % 2 == 0) ? FU : FD, cd[j % 6], cq[j % 6], "R7 hold one");

    repeat (4) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      fails++;
      $display("FAIL R6 pending results: actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    finish_run();
  end
endmodule